// File: doc/BRIEF.md
# Magic-Sequence Watchdog with Reset Cause

This block is a watchdog peripheral on a plain 32-bit register bus. Software sets an enable bit and a power-of-two delay field, and then services the counter before it runs out. To service it, software writes one fixed 32-bit key to the first service register and then a second fixed key to the second service register. A write that breaks this sequence is itself a fault. A counter that expires, a bad service sequence, a write to the soft-reset register and an external user-reset request all start a reset-request pulse of fixed length.

A 3-bit reset-cause code records the reason for the latest pulse. It survives the block's own pulses, and only the hard power-on reset clears it. Counting advances on a tick-enable input, which stands in for a slow counter clock. A level-high interrupt warns that half of the timeout has passed. Clearing the enable bit only arms a stop: the counter keeps running until the next valid service, so a single stray write cannot silence the watchdog.

Top module: `magic_watchdog`

## Requirements
- R1: While `rst_n` is low and right after it is released, `rst_req` and `irq` are 0, the configuration reads 0 and the cause code reads 0. The hard reset is the only way to return the cause code to 0.
- R2: Register offsets on `bus_addr`:
  - 0x0 is soft reset.
  - 0x4 is configuration: bit 31 is the enable bit and bits 4:0 are the delay field. Both read back as written.
  - 0x8 is the first service register. A read returns the cause code in bits 2:0 and zeros above.
  - 0xC is the second service register. It reads 0, as does every other offset.
- R3: An incorrect service sets the cause code to 2 and starts a reset pulse, whether or not the watchdog is enabled. Three cases are incorrect:
  - a write of any value other than 0xABCD1234 to offset 0x8;
  - a write to offset 0xC that does not directly follow a correct write to offset 0x8 (writes to other offsets in between are allowed);
  - a write of any value other than 0x4321DCBA to offset 0xC.
- R4: A valid service is 0xABCD1234 to offset 0x8 and then 0x4321DCBA to offset 0xC. It restarts the count from zero and raises no reset.
- R5: With delay field n and the enable bit set, the counter expires on the 2^(n+1)-th tick after the enabling write or the last valid service. Expiry sets the cause code to 1 and starts a reset pulse.
- R6: Each reset pulse holds `rst_req` high for exactly PULSE_LEN cycles, beginning in the cycle after the triggering event.
- R7: Writing the configuration with the enable bit clear does not stop a running counter, which can still expire. The stop takes effect at the next valid service, and after that no expiry occurs.
- R8: `irq` is high while the counter runs and at least 2^n ticks have been counted. A valid service clears it.
- R9: Any write to offset 0x0 sets the cause code to 3 and starts a reset pulse.
- R10: A high `user_rst` input for one cycle sets the cause code to 4 and starts a reset pulse.
- R11: Every reset event clears the configuration, the counter and the pending first key. The cause code keeps its new value after the pulse ends.
- R12: When events coincide, the cause code follows the priority user reset (4) > soft reset (3) > incorrect service (2) > expiry (1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rst_n | input | 1 | Hard power-on reset, active low |
| tick | input | 1 | Counter advance enable (slow-clock stand-in) |
| user_rst | input | 1 | External user reset request |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| rst_req | output | 1 | Reset request pulse |
| irq | output | 1 | Level-high half-timeout interrupt |

## Verification
The bench builds the block with the default 5-bit delay field and 32-bit keys, but shortens PULSE_LEN to 3 so that each pulse-length check ends quickly. Delay values 0, 1 and 2 bring expiry within 2, 4 and 8 ticks. This puts the half-timeout interrupt edge, the exact expiry tick and expiry coinciding with bus events within a few dozen cycles. The tests then exercise the pending stop, every incorrect-sequence variant and the priority of coincident causes directly.

// File: rtl/magic_watchdog.sv
module magic_watchdog #(
  parameter int DLY_W = 5,
  parameter int PULSE_LEN = 4,
  parameter int ADDR_W = 4,
  parameter logic [31:0] KEY_A = 32'hABCD1234,
  parameter logic [31:0] KEY_B = 32'h4321DCBA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              user_rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  output logic              rst_req,
  output logic              irq
);
  localparam int CNT_W = (1 << DLY_W) + 1;
  localparam int PW = $clog2(PULSE_LEN + 1);
  localparam logic [ADDR_W-1:0] A_SOFT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_T1   = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_T2   = ADDR_W'(12);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             cfg_en, running, armed;
  logic [DLY_W-1:0] cfg_dly;
  logic [CNT_W-1:0] count;
  logic [2:0]       cause, evt_code;
  logic [PW-1:0]    pulse_cnt;
  logic [DLY_W:0]   shamt;
  logic [CNT_W-1:0] limit, half;

  wire wr_soft = bus_we && bus_addr == A_SOFT;
  wire wr_cfg  = bus_we && bus_addr == A_CFG;
  wire wr_t1   = bus_we && bus_addr == A_T1;
  wire wr_t2   = bus_we && bus_addr == A_T2;

  assign shamt = {1'b0, cfg_dly} + {{DLY_W{1'b0}}, 1'b1};
  assign limit = ONE << shamt;
  assign half  = ONE << cfg_dly;

  wire service_ok = wr_t2 && armed && bus_wdata == KEY_B;
  wire bad_tickle = (wr_t1 && bus_wdata != KEY_A) || (wr_t2 && !service_ok);
  wire expire     = running && tick && !service_ok && count >= limit - ONE;
  wire evt        = user_rst || wr_soft || bad_tickle || expire;

  always_comb begin
    if (user_rst)        evt_code = 3'd4;
    else if (wr_soft)    evt_code = 3'd3;
    else if (bad_tickle) evt_code = 3'd2;
    else                 evt_code = 3'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en    <= 1'b0;
      cfg_dly   <= '0;
      running   <= 1'b0;
      armed     <= 1'b0;
      count     <= '0;
      cause     <= 3'd0;
      pulse_cnt <= '0;
    end else if (evt) begin
      cause     <= evt_code;
      pulse_cnt <= PW'(PULSE_LEN);
      cfg_en    <= 1'b0;
      cfg_dly   <= '0;
      running   <= 1'b0;
      armed     <= 1'b0;
      count     <= '0;
    end else begin
      if (pulse_cnt != '0) pulse_cnt <= pulse_cnt - PW'(1);
      if (wr_cfg) begin
        cfg_en  <= bus_wdata[31];
        cfg_dly <= bus_wdata[DLY_W-1:0];
      end
      if (wr_t1)      armed <= 1'b1;
      else if (wr_t2) armed <= 1'b0;
      if (service_ok) begin
        count   <= '0;
        running <= cfg_en;
      end else if (wr_cfg && bus_wdata[31] && !running) begin
        running <= 1'b1;
        count   <= '0;
      end else if (running && tick) begin
        count <= count + ONE;
      end
    end
  end

  assign rst_req = pulse_cnt != '0;
  assign irq     = running && count >= half;

  always_comb begin
    case (bus_addr)
      A_CFG:   bus_rdata = {cfg_en, {(31-DLY_W){1'b0}}, cfg_dly};
      A_T1:    bus_rdata = {29'd0, cause};
      default: bus_rdata = 32'd0;
    endcase
  end

  a_r4_service_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
    service_ok |=> !irq);
  a_r3_bad_tickle_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_tickle && !user_rst) |=> (cause == 3'd2 && rst_req));
  a_r7_stop_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cfg && !bus_wdata[31] && running && !user_rst && !expire) |=> running);
  a_r11_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> $stable(cause));
  a_r6_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(evt));
  a_r5_expire_resets: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (!running && rst_req));
endmodule

// File: tb/tb_magic_watchdog.sv
module tb_magic_watchdog;
  localparam int PLEN = 3;
  localparam logic [31:0] KA = 32'hABCD1234, KB = 32'h4321DCBA;

  logic clk = 0, rst_n = 0, tick = 0, user_rst = 0, bus_we = 0;
  logic [3:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic rst_req, irq;
  int checks = 0, fails = 0;
  bit done = 0;

  magic_watchdog #(.PULSE_LEN(PLEN)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .user_rst(user_rst),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_rdata(bus_rdata), .rst_req(rst_req), .irq(irq));

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    tick = 1; repeat (n) @(negedge clk); tick = 0;
  endtask

  task automatic pulse_len(input string req);
    int n = 0;
    while (rst_req && n < 50) begin n++; @(negedge clk); end
    chk(req, n, PLEN);
  endtask

  task automatic finish_pulse;
    while (rst_req) @(negedge clk);
  endtask

  task automatic do_service;
    wr(4'h8, KA); wr(4'hC, KB);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rst_n = 0; repeat (3) @(negedge clk); rst_n = 1; @(negedge clk);
    chk("R1 rst_req", rst_req, 0); chk("R1 irq", irq, 0);
    rd(4'h4, d); chk("R1 cfg", d, 0);
    rd(4'h8, d); chk("R1 cause", d, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(4'h4, 32'h0000_0013);
    rd(4'h4, d); chk("R2 cfg readback", d, 32'h0000_0013);
    rd(4'h0, d); chk("R2 soft reads 0", d, 0);
    rd(4'hC, d); chk("R2 tickle2 reads 0", d, 0);
    chk("R2 no pulse", rst_req, 0);
    wr(4'h4, 0);
  endtask

  task automatic t_timeout;
    logic [31:0] d;
    wr(4'h4, 32'h8000_0002);
    ticks(3); chk("R8 irq before half", irq, 0);
    ticks(1); chk("R8 irq at half", irq, 1);
    ticks(3); chk("R5 no expiry at 7", rst_req, 0);
    ticks(1); chk("R5 expiry at 8", rst_req, 1);
    rd(4'h8, d); chk("R5 cause timeout", d, 1);
    rd(4'h4, d); chk("R11 cfg cleared", d, 0);
    chk("R11 irq cleared", irq, 0);
    pulse_len("R6 pulse length");
    rd(4'h8, d); chk("R11 cause kept after pulse", d, 1);
  endtask

  task automatic t_service;
    logic [31:0] d;
    wr(4'h4, 32'h8000_0002);
    ticks(6); chk("R8 irq pending", irq, 1);
    do_service;
    chk("R4 irq cleared by service", irq, 0);
    chk("R4 no reset on service", rst_req, 0);
    ticks(7); chk("R4 count restarted", rst_req, 0);
    ticks(1); chk("R4 expiry after restart", rst_req, 1);
    finish_pulse;
  endtask

  task automatic bad_case(input string req, input int variant);
    logic [31:0] d;
    wr(4'h0, 0); finish_pulse;
    case (variant)
      0: wr(4'h8, 32'h1234_5678);
      1: wr(4'hC, KB);
      default: begin wr(4'h8, KA); wr(4'hC, 32'h4321_DCBB); end
    endcase
    chk(req, rst_req, 1);
    rd(4'h8, d); chk(req, d, 2);
    finish_pulse;
  endtask

  task automatic t_bad;
    bad_case("R3 wrong key A", 0);
    bad_case("R3 tickle2 without tickle1", 1);
    bad_case("R3 wrong key B", 2);
    wr(4'h8, KA); chk("R3 correct key A alone ok", rst_req, 0);
    wr(4'h4, 0);  wr(4'hC, KB); chk("R3 other write between ok", rst_req, 0);
    wr(4'hC, KB); chk("R3 repeated tickle2 is bad", rst_req, 1);
    finish_pulse;
  endtask

  task automatic t_stop;
    logic [31:0] d;
    wr(4'h4, 32'h8000_0001);
    ticks(2);
    wr(4'h4, 32'h0000_0001);
    rd(4'h4, d); chk("R2 enable cleared readback", d, 1);
    ticks(1); chk("R7 still counting", rst_req, 0);
    ticks(1); chk("R7 expiry despite disable", rst_req, 1);
    rd(4'h8, d); chk("R7 cause timeout", d, 1);
    finish_pulse;
    wr(4'h4, 32'h8000_0001); ticks(2);
    wr(4'h4, 32'h0000_0001);
    do_service;
    ticks(20);
    chk("R7 stopped after service", rst_req, 0);
    chk("R7 irq idle after stop", irq, 0);
  endtask

  task automatic t_soft_user;
    logic [31:0] d;
    wr(4'h4, 32'h8000_0004);
    wr(4'h0, 32'hDEAD_BEEF);
    chk("R9 soft pulse", rst_req, 1);
    rd(4'h8, d); chk("R9 cause soft", d, 3);
    rd(4'h4, d); chk("R11 cfg cleared by soft", d, 0);
    finish_pulse;
    @(negedge clk); user_rst = 1; @(negedge clk); user_rst = 0;
    chk("R10 user pulse", rst_req, 1);
    rd(4'h8, d); chk("R10 cause user", d, 4);
    pulse_len("R6 user pulse length");
  endtask

  task automatic t_priority;
    logic [31:0] d;
    @(negedge clk); user_rst = 1; bus_we = 1; bus_addr = 4'h0;
    @(negedge clk); user_rst = 0; bus_we = 0;
    rd(4'h8, d); chk("R12 user over soft", d, 4);
    finish_pulse;
    wr(4'h4, 32'h8000_0000); ticks(1);
    @(negedge clk); tick = 1; bus_we = 1; bus_addr = 4'h8; bus_wdata = 32'h1;
    @(negedge clk); tick = 0; bus_we = 0;
    rd(4'h8, d); chk("R12 bad tickle over expiry", d, 2);
    finish_pulse;
    wr(4'h4, 32'h8000_0000); ticks(1);
    @(negedge clk); tick = 1; bus_we = 1; bus_addr = 4'h0;
    @(negedge clk); tick = 0; bus_we = 0;
    rd(4'h8, d); chk("R12 soft over expiry", d, 3);
    finish_pulse;
  endtask

  task automatic t_hard_clear;
    logic [31:0] d;
    rd(4'h8, d); chk("R11 cause sticky", d, 3);
    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1; @(negedge clk);
    rd(4'h8, d); chk("R1 hard reset clears cause", d, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset;
    t_regs;
    t_timeout;
    t_service;
    t_bad;
    t_stop;
    t_soft_user;
    t_priority;
    t_hard_clear;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule